// File: doc/BRIEF.md
# Fluorescent Display Grid Scan and Brightness Timer

This block drives the grid side of a multiplexed dot-matrix fluorescent display. It walks a digit index across the active grids. Each grid gets a slot of 1024 clock cycles, and the grid is lit for a programmable part of that slot. The current digit index goes to the glyph path, so that the segment pattern for that digit is on the segment lines while its grid is lit. Two segment-gate outputs tell the segment drivers whether to pass glyph data or to force every segment high. Outside the lit window, both gates are low.

The block takes four inputs from a register file: a 10-bit brightness value, a 4-bit digit-count code, a write strobe with two mode bits for the all-lights override, and a standby request. It also watches the serial select line, because a falling edge on that line brings the block out of standby. The oscillator-run output tells the clock source whether it may run.

Top module: `vfd_grid_scan`

## Requirements
- R1: After reset the block is running (`osc_run_o`=1) with slot counter 0 and digit index 0. It scans 20 digits until the first wrap, whatever the code input is. The all-lights mode is dark, so `seg_pass_o`=0 and `seg_force_o`=0.
- R2: Slot cycle c of the current digit is lit when c is less than the clamped brightness. For example, a brightness of 0x3BF lights cycles 0 to 958. A brightness of 0 never lights a grid.
- R3: A brightness of 0x3C0 or above is clamped to 960. Cycles 0 to 959 are lit and cycle 960 is dark.
- R4: Code 0 selects 20 digits. A code k from 1 to 15 selects k+4 digits. The index counts up once per 1024-cycle slot and returns to 0 after the last active digit.
- R5: A new digit-count code takes effect only when the index next wraps to 0.
- R6: `grid_o` is either all zero or has exactly one bit set, and that bit is bit `digit_idx_o`. Digit index n drives grid n+1, so bit 0 is grid 1.
- R7: The mode is written with `light_wr_i`, using {H,L} = {`light_h_i`,`light_l_i`}. 00 selects normal: `seg_pass_o` follows the lit window. 01 selects dark: both gates are 0. 1x selects bright: `seg_force_o` follows the lit window. Grids keep scanning in every mode, and the two gates are never high together.
- R8: A standby request stops the oscillator (`osc_run_o`=0). It also holds all grids and both gates low and parks the index and slot counter at 0 from the next cycle on.
- R9: In standby, a falling edge on `sel_n_i` restarts the block on the next cycle. It resumes at slot cycle 0, digit 0, with the mode set to dark. A release takes priority over a standby request in the same cycle.
- R10: A reset while in standby leaves standby and restores every R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_i | input | 10 | Brightness: lit cycles per slot before clamping |
| digit_code_i | input | 4 | Digit-count code (0 means 20 digits, k means k+4) |
| light_wr_i | input | 1 | One-cycle strobe that loads the all-lights mode |
| light_h_i | input | 1 | All-lights H bit (force high) |
| light_l_i | input | 1 | All-lights L bit (force low) |
| standby_req_i | input | 1 | One-cycle standby request |
| sel_n_i | input | 1 | Serial select, active low; its falling edge ends standby |
| grid_o | output | 20 | Grid enables, bit n for digit n |
| digit_idx_o | output | 5 | Current digit index for the glyph path |
| seg_pass_o | output | 1 | Pass glyph segment data in this cycle |
| seg_force_o | output | 1 | Force all segments high in this cycle |
| osc_run_o | output | 1 | Oscillator may run |

## Verification
The bench checks the edges of the lit window: the last lit cycle and the first dark cycle at brightness 0x3BF, at the clamp of 0x3FF, and at 0. A comparator that is off by one, or a clamp that is missing, moves or stretches that edge. It changes the digit code in the middle of a frame and looks for the old count to finish before the new one applies. A design that switches at once would wrap early. It walks standby entry, release on a select falling edge and a reset while in standby. A release that kept the earlier mode, or that did not restart at digit 0, would light the segments or the wrong grid.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    typedef enum logic [1:0] {
        LM_NORMAL = 2'd0,
        LM_DARK   = 2'd1,
        LM_BRIGHT = 2'd2
    } light_mode_e;

endpackage

// File: rtl/vfd_duty_clamp.sv
module vfd_duty_clamp #(
    parameter int SLOT_W   = 10,
    parameter int DUTY_CAP = 960
) (
    input  logic [SLOT_W-1:0] duty_i,
    output logic [SLOT_W:0]   on_time_o
);
    localparam logic [SLOT_W:0] CAP = (SLOT_W+1)'(DUTY_CAP);

    logic [SLOT_W:0] wide;

    always_comb begin
        wide      = {1'b0, duty_i};
        on_time_o = (wide >= CAP) ? CAP : wide;
    end
endmodule

// File: rtl/vfd_digit_span.sv
module vfd_digit_span #(
    parameter int NUM_GRID    = 20,
    parameter int CODE_W      = 4,
    parameter int CODE_OFFSET = 4,
    parameter int IDX_W       = 5
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [IDX_W-1:0]  last_idx_o
);
    localparam logic [IDX_W-1:0] FULL_LAST = IDX_W'(NUM_GRID - 1);
    localparam logic [IDX_W-1:0] BIAS      = IDX_W'(CODE_OFFSET - 1);

    always_comb begin
        if (code_i == '0) last_idx_o = FULL_LAST;
        else              last_idx_o = IDX_W'(code_i) + BIAS;
    end
endmodule

// File: rtl/vfd_grid_onehot.sv
module vfd_grid_onehot #(
    parameter int NUM_GRID = 20,
    parameter int IDX_W    = 5
) (
    input  logic [IDX_W-1:0]    idx_i,
    input  logic                en_i,
    output logic [NUM_GRID-1:0] grid_o
);
    for (genvar g = 0; g < NUM_GRID; g++) begin : g_grid
        assign grid_o[g] = en_i && (idx_i == IDX_W'(g));
    end
endmodule

// File: rtl/vfd_grid_scan.sv
module vfd_grid_scan
    import vfd_scan_pkg::*;
#(
    parameter int NUM_GRID    = 20,
    parameter int SLOT_W      = 10,
    parameter int DUTY_CAP    = 960,
    parameter int CODE_W      = 4,
    parameter int CODE_OFFSET = 4,
    parameter int IDX_W       = $clog2(NUM_GRID)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SLOT_W-1:0]   duty_i,
    input  logic [CODE_W-1:0]   digit_code_i,
    input  logic                light_wr_i,
    input  logic                light_h_i,
    input  logic                light_l_i,
    input  logic                standby_req_i,
    input  logic                sel_n_i,
    output logic [NUM_GRID-1:0] grid_o,
    output logic [IDX_W-1:0]    digit_idx_o,
    output logic                seg_pass_o,
    output logic                seg_force_o,
    output logic                osc_run_o
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = '1;
    localparam logic [IDX_W-1:0]  RST_LAST  = IDX_W'(NUM_GRID - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] cnt;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        light_mode_e       mode;
        logic              stby;
        logic              sel_prev;
    } scan_state_t;

    scan_state_t st_d, st_q;
    logic [SLOT_W:0]   on_time;
    logic [IDX_W-1:0]  span_last;
    logic              sel_fall;
    logic              lit;

    vfd_duty_clamp #(.SLOT_W(SLOT_W), .DUTY_CAP(DUTY_CAP)) u_clamp (
        .duty_i    (duty_i),
        .on_time_o (on_time)
    );

    vfd_digit_span #(
        .NUM_GRID(NUM_GRID), .CODE_W(CODE_W),
        .CODE_OFFSET(CODE_OFFSET), .IDX_W(IDX_W)
    ) u_span (
        .code_i     (digit_code_i),
        .last_idx_o (span_last)
    );

    always_comb begin
        st_d          = st_q;
        st_d.sel_prev = sel_n_i;
        sel_fall      = st_q.sel_prev && !sel_n_i;
        if (st_q.stby) begin
            if (sel_fall) begin
                st_d.stby = 1'b0;
                st_d.mode = LM_DARK;
                st_d.cnt  = '0;
                st_d.idx  = '0;
            end
        end else if (standby_req_i) begin
            st_d.stby = 1'b1;
            st_d.cnt  = '0;
            st_d.idx  = '0;
        end else begin
            if (light_wr_i) begin
                if (light_h_i)      st_d.mode = LM_BRIGHT;
                else if (light_l_i) st_d.mode = LM_DARK;
                else                st_d.mode = LM_NORMAL;
            end
            if (st_q.cnt == SLOT_LAST) begin
                st_d.cnt = '0;
                if (st_q.idx == st_q.last) begin
                    st_d.idx  = '0;
                    st_d.last = span_last;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.last     <= RST_LAST;
            st_q.mode     <= LM_DARK;
            st_q.sel_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lit = !st_q.stby && ({1'b0, st_q.cnt} < on_time);

    vfd_grid_onehot #(.NUM_GRID(NUM_GRID), .IDX_W(IDX_W)) u_grid (
        .idx_i  (st_q.idx),
        .en_i   (lit),
        .grid_o (grid_o)
    );

    assign digit_idx_o = st_q.idx;
    assign seg_pass_o  = lit && (st_q.mode == LM_NORMAL);
    assign seg_force_o = lit && (st_q.mode == LM_BRIGHT);
    assign osc_run_o   = !st_q.stby;
endmodule

// File: rtl/vfd_grid_scan_chk.sv
module vfd_grid_scan_chk #(
    parameter int NUM_GRID = 20,
    parameter int SLOT_W   = 10,
    parameter int IDX_W    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic [SLOT_W-1:0]   duty_i,
    input logic                sel_n_i,
    input logic [NUM_GRID-1:0] grid_o,
    input logic [IDX_W-1:0]    digit_idx_o,
    input logic                seg_pass_o,
    input logic                seg_force_o,
    input logic                osc_run_o
);
    AST_GRID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grid_o)); // R6

    AST_GRID_AT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (grid_o != '0) |-> grid_o[digit_idx_o]); // R6

    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(digit_idx_o) < NUM_GRID); // R4

    AST_ZERO_DUTY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_i == '0) |-> (grid_o == '0)); // R2

    AST_STANDBY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run_o |-> (grid_o == '0 && digit_idx_o == '0 && !seg_pass_o && !seg_force_o)); // R8

    AST_SEG_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_pass_o || seg_force_o) |-> (grid_o != '0)); // R7

    AST_SEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(seg_pass_o && seg_force_o)); // R7

    AST_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_run_o && $fell(sel_n_i)) |=> (osc_run_o && !seg_pass_o && !seg_force_o)); // R9
endmodule

bind vfd_grid_scan vfd_grid_scan_chk #(
    .NUM_GRID(NUM_GRID), .SLOT_W(SLOT_W), .IDX_W(IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .duty_i      (duty_i),
    .sel_n_i     (sel_n_i),
    .grid_o      (grid_o),
    .digit_idx_o (digit_idx_o),
    .seg_pass_o  (seg_pass_o),
    .seg_force_o (seg_force_o),
    .osc_run_o   (osc_run_o)
);

// File: tb/sim_vfd_grid_scan.sv
`timescale 1ns/1ps
module sim_vfd_grid_scan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  duty_i = 10'd256;
    logic [3:0]  digit_code_i = 4'd0;
    logic        light_wr_i = 1'b0;
    logic        light_h_i = 1'b0;
    logic        light_l_i = 1'b0;
    logic        standby_req_i = 1'b0;
    logic        sel_n_i = 1'b1;
    logic [19:0] grid_o;
    logic [4:0]  digit_idx_o;
    logic        seg_pass_o;
    logic        seg_force_o;
    logic        osc_run_o;

    always #2 clk = ~clk;

    vfd_grid_scan u0 (
        .clk(clk), .rst_n(rst_n), .duty_i(duty_i), .digit_code_i(digit_code_i),
        .light_wr_i(light_wr_i), .light_h_i(light_h_i), .light_l_i(light_l_i),
        .standby_req_i(standby_req_i), .sel_n_i(sel_n_i),
        .grid_o(grid_o), .digit_idx_o(digit_idx_o), .seg_pass_o(seg_pass_o),
        .seg_force_o(seg_force_o), .osc_run_o(osc_run_o)
    );

    typedef struct {
        int          at;
        logic [19:0] grid;
        int          idx;
        bit          pass;
        bit          frc;
        bit          run;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    int   samp = 0;
    int   now = 0;
    bit   done = 1'b0;

    task automatic expect_at(int at, logic [19:0] g, int ix, bit p, bit f, bit r, string tag);
        exp_t e;
        e.at = at; e.grid = g; e.idx = ix; e.pass = p; e.frc = f; e.run = r; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: pops the head item when its sample number comes up.
    always @(negedge clk) begin
        if (!rst_n) begin
            samp = 0;
        end else begin
            while (q.size() > 0 && q[0].at < samp) begin
                checks++; fails++;
                $display("FAIL %s: sample %0d missed (actual sample %0d, expected %0d)",
                         q[0].tag, q[0].at, samp, q[0].at);
                void'(q.pop_front());
            end
            if (q.size() > 0 && q[0].at == samp) begin
                checks++;
                if (grid_o !== q[0].grid || int'(digit_idx_o) != q[0].idx ||
                    seg_pass_o !== q[0].pass || seg_force_o !== q[0].frc ||
                    osc_run_o !== q[0].run) begin
                    fails++;
                    $display("FAIL %s at sample %0d: actual grid=%h idx=%0d pass=%b force=%b run=%b, expected grid=%h idx=%0d pass=%b force=%b run=%b",
                             q[0].tag, samp, grid_o, digit_idx_o, seg_pass_o, seg_force_o, osc_run_o,
                             q[0].grid, q[0].idx, q[0].pass, q[0].frc, q[0].run);
                end
                void'(q.pop_front());
            end
            samp = samp + 1;
        end
    end

    task automatic run_to(int n);
        while (now < n) begin
            @(posedge clk);
            now++;
        end
    endtask

    task automatic write_mode(int at, bit h, bit l);
        run_to(at);
        light_wr_i <= 1'b1; light_h_i <= h; light_l_i <= l;
        run_to(at + 1);
        light_wr_i <= 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) @(posedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk);
        rst_n <= 1'b0;
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        now = 0;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst_n <= 1'b1;
        now = 0;

        expect_at(0,     20'h00001, 0, 0, 0, 1, "R1 reset state");
        expect_at(255,   20'h00001, 0, 0, 0, 1, "R2 last lit cycle at 256");
        expect_at(256,   20'h00000, 0, 0, 0, 1, "R2 first dark cycle at 256");
        expect_at(1034,  20'h00002, 1, 1, 0, 1, "R7 normal mode passes, R4 index 1");
        expect_at(1280,  20'h00000, 1, 0, 0, 1, "R7 pass closes with window");
        expect_at(3007,  20'h00004, 2, 1, 0, 1, "R3 clamp last lit 959");
        expect_at(3008,  20'h00000, 2, 0, 0, 1, "R3 clamp dark at 960");
        expect_at(4030,  20'h00008, 3, 1, 0, 1, "R2 0x3BF last lit 958");
        expect_at(4031,  20'h00000, 3, 0, 0, 1, "R2 0x3BF dark at 959");
        expect_at(4200,  20'h00000, 4, 0, 0, 1, "R2 zero duty dark");
        expect_at(5125,  20'h00020, 5, 0, 1, 1, "R7 bright forces high");
        expect_at(5420,  20'h00000, 5, 0, 0, 1, "R7 force closes with window");
        expect_at(6145,  20'h00040, 6, 0, 1, 1, "R7 H and L both set is bright");
        expect_at(7169,  20'h00080, 7, 0, 0, 1, "R7 dark mode still scans grid");
        expect_at(19456, 20'h80000, 19, 1, 0, 1, "R6 digit 19 drives top grid");
        expect_at(20481, 20'h00001, 0, 1, 0, 1, "R4 wrap after 20 digits");
        expect_at(25601, 20'h00020, 5, 1, 0, 1, "R5 old count holds mid frame");
        expect_at(39937, 20'h80000, 19, 1, 0, 1, "R5 frame completes 20 digits");
        expect_at(45057, 20'h00010, 4, 1, 0, 1, "R4 code 1 last digit 4");
        expect_at(46081, 20'h00001, 0, 1, 0, 1, "R4 code 1 wraps after 5");
        expect_at(69633, 20'h40000, 18, 1, 0, 1, "R4 code 15 last digit 18");
        expect_at(70657, 20'h00001, 0, 1, 0, 1, "R4 code 15 wraps after 19");
        expect_at(71001, 20'h00000, 0, 0, 0, 0, "R8 standby entry dark");
        expect_at(72000, 20'h00000, 0, 0, 0, 0, "R8 standby held");
        expect_at(72100, 20'h00000, 0, 0, 0, 0, "R9 still standby before edge");
        expect_at(72101, 20'h00001, 0, 0, 0, 1, "R9 released, dark mode, slot 0");
        expect_at(72301, 20'h00001, 0, 1, 0, 1, "R9 resumes scanning, normal again");
        expect_at(72501, 20'h00000, 0, 0, 0, 0, "R8 second standby");
        expect_at(72600, 20'h00000, 0, 0, 0, 0, "R8 second standby held");

        write_mode(300, 1'b0, 1'b0);
        run_to(1500);  duty_i <= 10'h3FF;
        run_to(3100);  duty_i <= 10'h3BF;
        run_to(4100);  duty_i <= 10'h000;
        run_to(4500);  duty_i <= 10'd256;
        write_mode(4600, 1'b1, 1'b0);
        write_mode(5500, 1'b1, 1'b1);
        write_mode(6300, 1'b0, 1'b1);
        write_mode(7300, 1'b0, 1'b0);
        run_to(20500); digit_code_i <= 4'd1;
        run_to(46200); digit_code_i <= 4'd15;
        run_to(71000); standby_req_i <= 1'b1;
        run_to(71001); standby_req_i <= 1'b0;
        run_to(72100); sel_n_i <= 1'b0;
        run_to(72150); sel_n_i <= 1'b1;
        write_mode(72200, 1'b0, 1'b0);
        run_to(72500); standby_req_i <= 1'b1;
        run_to(72501); standby_req_i <= 1'b0;
        drain();

        // R10: reset while in standby
        do_reset();
        expect_at(0,     20'h00001, 0, 0, 0, 1, "R10 reset leaves standby");
        expect_at(19457, 20'h80000, 19, 0, 0, 1, "R10 reset restores 20 digits");
        run_to(19500);
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual no completion, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule